// File: doc/BRIEF.md
# Dual-Address Synchronous RAM with Port-to-Port Pass-Through

This block is a synchronous memory with two fully independent ports, X and Y. Each port carries its own address, write data, write enable, pass-through request, a pair of chip enables and an output enable. In any one cycle each port can read a word, write a word or stay idle. Either port can also forward the word on its data input straight to the opposite port's output. All requests are captured on the rising clock edge, and returned data passes through an output register before it reaches the port.

Fixed rules settle collisions on a shared address. Two reads both return the stored word. A read paired with a write returns the contents from before the write. Two writes store only port Y's word. A forwarded word replaces array data on the receiving port. Each bidirectional data pin is modelled as a separate data input, a registered data output and a drive-enable. The output enable gates the drive-enable without waiting for the clock. Depth (2^ADDR_W words) and word width (DATA_W) are parameters.

Top module: `dxram_top`

## Requirements
- R1: A request present before rising edge n has its read or forwarded word at the port output only after edge n+1. Right after edge n, the output still shows its earlier value.
- R2: A port is selected only while its cs1_n input is 0 and its cs2 input is 1. A port that is not selected neither reads nor writes, and its drive-enable is 0 for that operation.
- R3: A selected port with we_n = 0 stores its data word at its address. Writes from both ports to different addresses both commit in the same cycle.
- R4: When one port writes and the other port reads the same address in one cycle, the reader returns the word stored before that write. The write then commits.
- R5: When both ports write the same address in one cycle, the array keeps port Y's word.
- R6: When both ports read the same address in one cycle, both return the stored word.
- R7: A selected port with pt_n = 0 forwards its data input to the other port's output register. The forwarded word takes the place of a read on that port. A write on the receiving port takes priority over the forwarded word, and the word is then dropped.
- R8: The drive-enable of a port is 1 only after an operation that loaded its output (a read or a received forwarded word) and only while oe_n is 0. After a write on that port it is 0.
- R9: oe_n = 1 forces the drive-enable to 0 within the same cycle, with no clock edge needed. Returning oe_n to 0 restores it.
- R10: After a write, or an operation in which the port is not selected and receives no forwarded word, the port's output keeps its previous value.
- R11: Requests present during the first clock cycle after reset is released are ignored. No write commits, no read or forward loads an output, and both drive-enables stay 0.
- R12: During and right after reset, both data outputs are 0 and both drive-enables are 0. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x_addr | input | ADDR_W | Port X word address |
| x_din | input | DATA_W | Port X write or forward data |
| x_we_n | input | 1 | Port X write enable, active low |
| x_pt_n | input | 1 | Port X forward-to-Y request, active low |
| x_cs1_n | input | 1 | Port X chip enable, active low |
| x_cs2 | input | 1 | Port X chip enable, active high |
| x_oe_n | input | 1 | Port X output enable, active low, unclocked |
| x_dout | output | DATA_W | Port X registered output data |
| x_drive | output | 1 | Port X pin drive-enable |
| y_addr | input | ADDR_W | Port Y word address |
| y_din | input | DATA_W | Port Y write or forward data |
| y_we_n | input | 1 | Port Y write enable, active low |
| y_pt_n | input | 1 | Port Y forward-to-X request, active low |
| y_cs1_n | input | 1 | Port Y chip enable, active low |
| y_cs2 | input | 1 | Port Y chip enable, active high |
| y_oe_n | input | 1 | Port Y output enable, active low, unclocked |
| y_dout | output | DATA_W | Port Y registered output data |
| y_drive | output | 1 | Port Y pin drive-enable |

## Verification
Some rules are checked on every cycle by the assertions. These are the output-enable gating of the drive-enable, the quiet drive-enable after a write or an unselected operation, the output holding its value when nothing loads it, and the forwarded word arriving two edges after its request. Other behaviour depends on array contents or on a single moment, so only the bench scenarios can show it. This covers the stored word after read-before-write and dual-write collisions, and both ports reading one address. It also covers the ignored warm-up cycle, the reset values and the exact edge on which a read result first appears. The bench checks these against its own reference array over a sweep of every select, write and forward combination, on shared and distinct addresses.

// File: rtl/dxram_pkg.sv
// Shared definitions for the dual-address RAM.
// Assumes: one operation kind per port per cycle, decoded from the pins.
package dxram_pkg;

    // Decoded per-port operation held in the request register
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

endpackage

// File: rtl/dxram_port_in.sv
// Request capture for one port: decodes selection and operation from the
// pins and registers the result with address and data on the rising edge.
// Assumes: accept is low in the ignored warm-up cycle after reset.
module dxram_port_in
    import dxram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              we_n,
    input  logic              pt_n,
    input  logic              cs1_n,
    input  logic              cs2,
    output port_op_e          op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              fwd_q
);

    logic     sel;
    port_op_e op_d;

    // Selection needs both enables plus the warm-up gate
    always_comb begin
        sel  = !cs1_n && cs2 && accept;
        op_d = OP_NONE;
        if (sel) op_d = we_n ? OP_READ : OP_WRITE;
    end

    // Control register: cleared to idle in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_NONE;
            fwd_q <= 1'b0;
        end else begin
            op_q  <= op_d;
            fwd_q <= sel && !pt_n;
        end
    end

    // Address and data register: no reset needed, qualified by op_q
    always_ff @(posedge clk) begin
        addr_q <= addr;
        din_q  <= din;
    end

endmodule

// File: rtl/dxram_array.sv
// Storage array with two address ports. Reads are combinational from the
// registered addresses, so a read sees the word from before any write
// committed on the same edge. On equal write addresses port Y wins.
// Assumes: addresses and ops come from the request registers.
module dxram_array
    import dxram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  port_op_e          x_op,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_wdata,
    input  port_op_e          y_op,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_wdata,
    output logic [DATA_W-1:0] x_rdata,
    output logic [DATA_W-1:0] y_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              x_wr;
    logic              y_wr;
    logic              x_shadowed;

    // Write qualification; X yields to Y on the same address
    always_comb begin
        x_wr       = (x_op == OP_WRITE);
        y_wr       = (y_op == OP_WRITE);
        x_shadowed = y_wr && (x_addr == y_addr);
    end

    // Commit writes on the edge after capture
    always_ff @(posedge clk) begin
        if (y_wr) mem[y_addr] <= y_wdata;
        if (x_wr && !x_shadowed) mem[x_addr] <= x_wdata;
    end

    // Old-data read ports
    assign x_rdata = mem[x_addr];
    assign y_rdata = mem[y_addr];

endmodule

// File: rtl/dxram_out_stage.sv
// Output register and drive-enable for one port. A forwarded word from the
// other port beats a local read; a local write blocks both and clears the
// drive; anything else holds the data and clears the drive.
// Assumes: oe_n is asynchronous and only gates the drive-enable.
module dxram_out_stage
    import dxram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_e          own_op,
    input  logic [DATA_W-1:0] own_rdata,
    input  logic              fwd_in,
    input  logic [DATA_W-1:0] fwd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);

    logic [DATA_W-1:0] data_q;
    logic              drv_q;

    // Output register update by priority: write, forward, read, hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            drv_q  <= 1'b0;
        end else if (own_op == OP_WRITE) begin
            drv_q  <= 1'b0;
        end else if (fwd_in) begin
            data_q <= fwd_data;
            drv_q  <= 1'b1;
        end else if (own_op == OP_READ) begin
            data_q <= own_rdata;
            drv_q  <= 1'b1;
        end else begin
            drv_q  <= 1'b0;
        end
    end

    // Unclocked output-enable gating
    assign dout  = data_q;
    assign drive = drv_q && !oe_n;

endmodule

// File: rtl/dxram_top.sv
// Dual-address synchronous RAM with port-to-port pass-through.
// Two request registers feed a shared array and two output stages.
// Requests in the first cycle after reset release are discarded.
// Assumes: single clock, synchronous active-low reset.
module dxram_top
    import dxram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_din,
    input  logic              x_we_n,
    input  logic              x_pt_n,
    input  logic              x_cs1_n,
    input  logic              x_cs2,
    input  logic              x_oe_n,
    output logic [DATA_W-1:0] x_dout,
    output logic              x_drive,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_din,
    input  logic              y_we_n,
    input  logic              y_pt_n,
    input  logic              y_cs1_n,
    input  logic              y_cs2,
    input  logic              y_oe_n,
    output logic [DATA_W-1:0] y_dout,
    output logic              y_drive
);

    logic              ready_q;
    port_op_e          xop_q, yop_q;
    logic [ADDR_W-1:0] xaddr_q, yaddr_q;
    logic [DATA_W-1:0] xdin_q, ydin_q;
    logic              xfwd_q, yfwd_q;
    logic [DATA_W-1:0] xrd, yrd;

    // Warm-up gate: low for the first edge after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    dxram_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) x_in_i (
        .clk(clk), .rst_n(rst_n), .accept(ready_q),
        .addr(x_addr), .din(x_din), .we_n(x_we_n), .pt_n(x_pt_n),
        .cs1_n(x_cs1_n), .cs2(x_cs2),
        .op_q(xop_q), .addr_q(xaddr_q), .din_q(xdin_q), .fwd_q(xfwd_q)
    );

    dxram_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) y_in_i (
        .clk(clk), .rst_n(rst_n), .accept(ready_q),
        .addr(y_addr), .din(y_din), .we_n(y_we_n), .pt_n(y_pt_n),
        .cs1_n(y_cs1_n), .cs2(y_cs2),
        .op_q(yop_q), .addr_q(yaddr_q), .din_q(ydin_q), .fwd_q(yfwd_q)
    );

    dxram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk),
        .x_op(xop_q), .x_addr(xaddr_q), .x_wdata(xdin_q),
        .y_op(yop_q), .y_addr(yaddr_q), .y_wdata(ydin_q),
        .x_rdata(xrd), .y_rdata(yrd)
    );

    // X output receives Y's forwarded word
    dxram_out_stage #(.DATA_W(DATA_W)) x_out_i (
        .clk(clk), .rst_n(rst_n), .own_op(xop_q), .own_rdata(xrd),
        .fwd_in(yfwd_q), .fwd_data(ydin_q), .oe_n(x_oe_n),
        .dout(x_dout), .drive(x_drive)
    );

    // Y output receives X's forwarded word
    dxram_out_stage #(.DATA_W(DATA_W)) y_out_i (
        .clk(clk), .rst_n(rst_n), .own_op(yop_q), .own_rdata(yrd),
        .fwd_in(xfwd_q), .fwd_data(xdin_q), .oe_n(y_oe_n),
        .dout(y_dout), .drive(y_drive)
    );

endmodule

// File: rtl/dxram_chk.sv
// Port-level checker for dxram_top, bound into every instance.
// Assumes: request-to-output distance of two rising edges.
module dxram_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] x_din,
    input logic              x_we_n,
    input logic              x_pt_n,
    input logic              x_cs1_n,
    input logic              x_cs2,
    input logic              x_oe_n,
    input logic [DATA_W-1:0] x_dout,
    input logic              x_drive,
    input logic [DATA_W-1:0] y_din,
    input logic              y_we_n,
    input logic              y_pt_n,
    input logic              y_cs1_n,
    input logic              y_cs2,
    input logic              y_oe_n,
    input logic [DATA_W-1:0] y_dout,
    input logic              y_drive
);

    localparam int AW_UNUSED = ADDR_W;

    logic [1:0] age_q;
    logic       xs, ys;

    // Edges since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign xs = !x_cs1_n && x_cs2;
    assign ys = !y_cs1_n && y_cs2;

    // R9
    oe_gate_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_oe_n |-> !x_drive);
    // R9
    oe_gate_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_oe_n |-> !y_drive);
    // R8
    wr_quiet_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(xs && !x_we_n, 2)) |-> !x_drive);
    // R8
    wr_quiet_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(ys && !y_we_n, 2)) |-> !y_drive);
    // R2
    desel_quiet_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(!xs && !(ys && !y_pt_n), 2)) |-> !x_drive);
    // R2
    desel_quiet_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(!ys && !(xs && !x_pt_n), 2)) |-> !y_drive);
    // R10
    hold_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(!(xs && x_we_n) && !(ys && !y_pt_n), 2))
        |-> $stable(x_dout));
    // R10
    hold_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(!(ys && y_we_n) && !(xs && !x_pt_n), 2))
        |-> $stable(y_dout));
    // R7
    fwd_xy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(xs && !x_pt_n && !(ys && !y_we_n), 2))
        |-> (y_dout == $past(x_din, 2)));
    // R7
    fwd_yx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(ys && !y_pt_n && !(xs && !x_we_n), 2))
        |-> (x_dout == $past(y_din, 2)));

    initial begin
        addr_width_chk: assert (AW_UNUSED > 0);
    end

endmodule

bind dxram_top dxram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .x_din(x_din), .x_we_n(x_we_n), .x_pt_n(x_pt_n),
    .x_cs1_n(x_cs1_n), .x_cs2(x_cs2), .x_oe_n(x_oe_n),
    .x_dout(x_dout), .x_drive(x_drive),
    .y_din(y_din), .y_we_n(y_we_n), .y_pt_n(y_pt_n),
    .y_cs1_n(y_cs1_n), .y_cs2(y_cs2), .y_oe_n(y_oe_n),
    .y_dout(y_dout), .y_drive(y_drive)
);

// File: tb/dxram_top_tb_top.sv
// Sweep bench for dxram_top on a 16 x 8 configuration with a reference array.
module dxram_top_tb_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic [DW-1:0] x_din = '0, y_din = '0;
    logic          x_we_n = 1'b1, x_pt_n = 1'b1, x_cs1_n = 1'b1, x_cs2 = 1'b0, x_oe_n = 1'b0;
    logic          y_we_n = 1'b1, y_pt_n = 1'b1, y_cs1_n = 1'b1, y_cs2 = 1'b0, y_oe_n = 1'b0;
    logic [DW-1:0] x_dout, y_dout;
    logic          x_drive, y_drive;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] exp_xq = '0, exp_yq = '0;
    logic          exp_xd = 1'b0, exp_yd = 1'b0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    dxram_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .x_addr(x_addr), .x_din(x_din), .x_we_n(x_we_n), .x_pt_n(x_pt_n),
        .x_cs1_n(x_cs1_n), .x_cs2(x_cs2), .x_oe_n(x_oe_n),
        .x_dout(x_dout), .x_drive(x_drive),
        .y_addr(y_addr), .y_din(y_din), .y_we_n(y_we_n), .y_pt_n(y_pt_n),
        .y_cs1_n(y_cs1_n), .y_cs2(y_cs2), .y_oe_n(y_oe_n),
        .y_dout(y_dout), .y_drive(y_drive)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        x_cs1_n = 1'b1; x_cs2 = 1'b0; x_we_n = 1'b1; x_pt_n = 1'b1;
        y_cs1_n = 1'b1; y_cs2 = 1'b0; y_we_n = 1'b1; y_pt_n = 1'b1;
    endtask

    // One operation: drive, wait two edges, compare with the model
    task automatic step(input string tag,
                        input logic xc1, input logic xc2, input logic xwe, input logic xpt,
                        input logic [AW-1:0] xa, input logic [DW-1:0] xd,
                        input logic yc1, input logic yc2, input logic ywe, input logic ypt,
                        input logic [AW-1:0] ya, input logic [DW-1:0] yd);
        logic xs, ys, xw, yw;
        logic [DW-1:0] rx, ry;
        xs = !xc1 && xc2; ys = !yc1 && yc2;
        xw = xs && !xwe;  yw = ys && !ywe;
        rx = ref_mem[xa]; ry = ref_mem[ya];
        x_cs1_n = xc1; x_cs2 = xc2; x_we_n = xwe; x_pt_n = xpt; x_addr = xa; x_din = xd;
        y_cs1_n = yc1; y_cs2 = yc2; y_we_n = ywe; y_pt_n = ypt; y_addr = ya; y_din = yd;
        @(posedge clk); #1;
        check({tag, " R1 x not yet updated"}, x_dout, exp_xq);
        check({tag, " R1 y not yet updated"}, y_dout, exp_yq);
        idle();
        @(posedge clk); #1;
        if (yw) ref_mem[ya] = yd;
        if (xw && !(yw && xa == ya)) ref_mem[xa] = xd;
        if (xw)                  exp_xd = 1'b0;
        else if (ys && !ypt)     begin exp_xq = yd; exp_xd = 1'b1; end
        else if (xs)             begin exp_xq = rx; exp_xd = 1'b1; end
        else                     exp_xd = 1'b0;
        if (yw)                  exp_yd = 1'b0;
        else if (xs && !xpt)     begin exp_yq = xd; exp_yd = 1'b1; end
        else if (ys)             begin exp_yq = ry; exp_yd = 1'b1; end
        else                     exp_yd = 1'b0;
        check({tag, " x_dout"},  x_dout,  exp_xq);
        check({tag, " x_drive"}, x_drive, exp_xd);
        check({tag, " y_dout"},  y_dout,  exp_yq);
        check({tag, " y_drive"}, y_drive, exp_yd);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < DEPTH; a++)
            step(tag, 0, 1, 1, 1, AW'(a), '0, 0, 1, 1, 1, AW'(DEPTH - 1 - a), '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R12: reset values
        check("R12 x_dout in reset", x_dout, 0);
        check("R12 x_drive in reset", x_drive, 0);
        check("R12 y_drive in reset", y_drive, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R12 y_dout after reset", y_dout, 0);

        // R3: fill, both ports writing distinct addresses together
        for (int a = 0; a < DEPTH / 2; a++)
            step("R3 dual fill", 0, 1, 0, 1, AW'(a), DW'(a * 37 + 5),
                 0, 1, 0, 1, AW'(a + DEPTH / 2), DW'(a * 53 + 11));
        read_all("R3 readback");

        // R6: both ports read one address
        for (int a = 0; a < DEPTH; a++)
            step("R6 same read", 0, 1, 1, 1, AW'(a), '0, 0, 1, 1, 1, AW'(a), '0);

        // R4: write/read collisions in both directions; R5: dual write
        for (int a = 0; a < DEPTH; a++) begin
            step("R4 x writes y reads", 0, 1, 0, 1, AW'(a), DW'(a * 7 + 100),
                 0, 1, 1, 1, AW'(a), '0);
            step("R4 y writes x reads", 0, 1, 1, 1, AW'(a), '0,
                 0, 1, 0, 1, AW'(a), DW'(a * 11 + 3));
            step("R5 dual write", 0, 1, 0, 1, AW'(a), DW'(a * 13 + 1),
                 0, 1, 0, 1, AW'(a), DW'(a * 17 + 200));
        end
        read_all("R5 readback");

        // R10: a write after a read keeps the output value
        step("R10 load", 0, 1, 1, 1, 4'd2, '0, 0, 1, 1, 1, 4'd9, '0);
        step("R10 write holds", 0, 1, 0, 1, 4'd3, 8'h3c, 1, 1, 1, 1, 4'd4, '0);

        // R9: output enable acts between edges
        step("R9 setup read", 0, 1, 1, 1, 4'd5, '0, 0, 1, 1, 1, 4'd6, '0);
        x_oe_n = 1'b1; #1;
        check("R9 x_drive with oe_n high", x_drive, 0);
        x_oe_n = 1'b0; #1;
        check("R9 x_drive with oe_n low", x_drive, 1);
        @(negedge clk);

        // R7 with R2 and R8: every select/write/forward combination
        for (int c = 0; c < 256; c++) begin
            logic [1:0] xo, yo;
            logic [AW-1:0] xa, ya;
            xo = c[1:0]; yo = c[3:2];
            xa = AW'(c * 3);
            ya = c[6] ? xa : AW'(xa ^ 4'd5);
            step("R7 R2 R8 sweep",
                 xo == 2'd0, xo != 2'd1, xo != 2'd3, c[4], xa, DW'(c * 29 + 7),
                 yo == 2'd0, yo != 2'd1, yo != 2'd3, c[5], ya, DW'(c * 41 + 19));
        end
        read_all("R7 readback");

        // R11: requests in the cycle right after reset release are ignored
        rst_n = 1'b0; exp_xq = '0; exp_yq = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        x_cs1_n = 1'b0; x_cs2 = 1'b1; x_we_n = 1'b0; x_pt_n = 1'b0; x_addr = 4'd3; x_din = 8'h5a;
        y_cs1_n = 1'b0; y_cs2 = 1'b1; y_we_n = 1'b1; y_addr = 4'd7;
        @(posedge clk); #1;
        idle();
        @(posedge clk); #1;
        check("R11 y_drive after ignored cycle", y_drive, 0);
        check("R11 y_dout after ignored cycle", y_dout, 0);
        check("R11 x_drive after ignored cycle", x_drive, 0);
        step("R11 no write committed", 0, 1, 1, 1, 4'd3, '0, 0, 1, 1, 1, 4'd7, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule